// File: doc/BRIEF.md
# Set/Reset Storage Cell with Selectable Dominance

This block models a cross-coupled set/reset storage cell as clocked logic sampled on a fast system clock. Two request inputs, set and clear, move the stored bit. Their active level is fixed at build time, either high or low. The case where both requests are active at once is a defined condition rather than a fault. In that case both outputs take the value of whichever request has been chosen to win, so they stop being complements. A flag marks every cycle in which that happens.

When no request is active, the stored bit holds. When exactly one request is active, the bit goes to 1 or 0. Polarity and dominance are chosen independently, so all four combinations are available. All outputs come from registers. A synchronous active-high system reset puts the cell in the cleared state.

Top module: `dlat_core`

## Requirements
- R1: In the cycle after a clock edge that samples `rst` high, `q`=0, `q_n`=1 and `both_flag`=0.
- R2: With neither request active at an edge, `q` keeps its value and `q_n` is the complement of `q`.
- R3: With only the set request active at an edge, `q`=1 and `q_n`=0 after that edge.
- R4: With only the clear request active at an edge, `q`=0 and `q_n`=1 after that edge.
- R5: With `SET_WINS`=0 and both requests active at an edge, `q`=0 and `q_n`=0 after that edge.
- R6: With `SET_WINS`=1 and both requests active at an edge, `q`=1 and `q_n`=1 after that edge.
- R7: After any edge at which the two requests were not both active, `q_n` equals the complement of `q`.
- R8: `both_flag` is 1 after an edge exactly when both requests were active at that edge and `rst` was low.
- R9: With `ACTIVE_HIGH`=1 a request is active when its pin is 1. With `ACTIVE_HIGH`=0 a request is active when its pin is 0, so the both-active pattern is 11 or 00 respectively.
- R10: When both requests are released together, `q` holds the winning value and `q_n` returns to its complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| set_in | input | 1 | Set request, active level given by `ACTIVE_HIGH` |
| clr_in | input | 1 | Clear request, active level given by `ACTIVE_HIGH` |
| q | output | 1 | Stored bit |
| q_n | output | 1 | Second output: complement of `q`, or the winning value when both requests are active |
| both_flag | output | 1 | High when both requests were active at the last edge |

## Verification
Every result, including reset, is due exactly one clock edge after the inputs that cause it are sampled, because the request pins pass through combinational decode into a single output register.

The bench changes the pins at a falling edge and advances its behavioural model for that rising edge. It then compares all three outputs at the following falling edge, so each comparison lands in the cycle the result is due.

Four instances, one for each combination of polarity and dominance, are driven with the same logical request stream. This covers both-active entry and exit, reset asserted during a both-active cycle, and a long random stretch.

// File: rtl/dlat_pkg.sv
package dlat_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_BOTH = 2'b11
  } act_t;
endpackage

// File: rtl/dlat_polarity.sv
module dlat_polarity #(
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic set_pin,
  input  logic clr_pin,
  output logic set_act,
  output logic clr_act
);
  generate
    if (ACTIVE_HIGH) begin : g_high
      assign set_act = set_pin;
      assign clr_act = clr_pin;
    end else begin : g_low
      assign set_act = ~set_pin;
      assign clr_act = ~clr_pin;
    end
  endgenerate
endmodule

// File: rtl/dlat_decide.sv
module dlat_decide
  import dlat_pkg::*;
#(
  parameter bit SET_WINS = 1'b0
) (
  input  logic set_act,
  input  logic clr_act,
  input  logic q_cur,
  output act_t act,
  output logic q_nxt,
  output logic qn_nxt,
  output logic flag_nxt
);
  always_comb begin
    act = act_t'({set_act, clr_act});
    q_nxt = q_cur;
    qn_nxt = ~q_cur;
    flag_nxt = 1'b0;
    unique case (act)
      ACT_HOLD: begin
        q_nxt = q_cur;
        qn_nxt = ~q_cur;
      end
      ACT_SET: begin
        q_nxt = 1'b1;
        qn_nxt = 1'b0;
      end
      ACT_CLR: begin
        q_nxt = 1'b0;
        qn_nxt = 1'b1;
      end
      ACT_BOTH: begin
        q_nxt = SET_WINS;
        qn_nxt = SET_WINS;
        flag_nxt = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dlat_regs.sv
module dlat_regs
  import dlat_pkg::*;
#(
  parameter bit SET_WINS = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  act_t act,
  input  logic q_nxt,
  input  logic qn_nxt,
  input  logic flag_nxt,
  output logic q,
  output logic q_n,
  output logic both_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
      q_n <= 1'b1;
      both_flag <= 1'b0;
    end else begin
      q <= q_nxt;
      q_n <= qn_nxt;
      both_flag <= flag_nxt;
    end
  end

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(negedge clk) begin
    if (rst_d === 1'b1) begin
      a_r1_reset_state: assert (q == 1'b0 && q_n == 1'b1 && both_flag == 1'b0)
        else $error("R1 reset state wrong");
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_HOLD) |=> (q == $past(q)));
  a_r3_set: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_SET) |=> (q && !q_n));
  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_CLR) |=> (!q && q_n));
  a_r5_r6_both: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_BOTH) |=> (both_flag && q == SET_WINS && q_n == SET_WINS));
  a_r7_complement: assert property (@(posedge clk) disable iff (rst)
    !both_flag |-> (q_n == !q));
  a_r8_flag_only_both: assert property (@(posedge clk) disable iff (rst)
    (act != ACT_BOTH) |=> !both_flag);
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    (both_flag && act == ACT_HOLD) |=> (q == SET_WINS && q_n == !SET_WINS));
endmodule

// File: rtl/dlat_core.sv
module dlat_core
  import dlat_pkg::*;
#(
  parameter bit ACTIVE_HIGH = 1'b1,
  parameter bit SET_WINS = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_in,
  input  logic clr_in,
  output logic q,
  output logic q_n,
  output logic both_flag
);
  logic set_act, clr_act, q_nxt, qn_nxt, flag_nxt;
  act_t act;

  dlat_polarity #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_pol (
    .set_pin(set_in), .clr_pin(clr_in),
    .set_act(set_act), .clr_act(clr_act)
  );

  dlat_decide #(.SET_WINS(SET_WINS)) u_dec (
    .set_act(set_act), .clr_act(clr_act), .q_cur(q),
    .act(act), .q_nxt(q_nxt), .qn_nxt(qn_nxt), .flag_nxt(flag_nxt)
  );

  dlat_regs #(.SET_WINS(SET_WINS)) u_regs (
    .clk(clk), .rst(rst), .act(act),
    .q_nxt(q_nxt), .qn_nxt(qn_nxt), .flag_nxt(flag_nxt),
    .q(q), .q_n(q_n), .both_flag(both_flag)
  );
endmodule

// File: tb/dlat_core_bench.sv
module dlat_core_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic [3:0] s_pin, r_pin, q_o, qn_o, f_o;
  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  // variant v: polarity active-high when v<2, set wins when v is odd
  dlat_core #(.ACTIVE_HIGH(1'b1), .SET_WINS(1'b0)) u_dlat_core (
    .clk(clk), .rst(rst), .set_in(s_pin[0]), .clr_in(r_pin[0]),
    .q(q_o[0]), .q_n(qn_o[0]), .both_flag(f_o[0]));
  dlat_core #(.ACTIVE_HIGH(1'b1), .SET_WINS(1'b1)) u_dlat_core_hs (
    .clk(clk), .rst(rst), .set_in(s_pin[1]), .clr_in(r_pin[1]),
    .q(q_o[1]), .q_n(qn_o[1]), .both_flag(f_o[1]));
  dlat_core #(.ACTIVE_HIGH(1'b0), .SET_WINS(1'b0)) u_dlat_core_lr (
    .clk(clk), .rst(rst), .set_in(s_pin[2]), .clr_in(r_pin[2]),
    .q(q_o[2]), .q_n(qn_o[2]), .both_flag(f_o[2]));
  dlat_core #(.ACTIVE_HIGH(1'b0), .SET_WINS(1'b1)) u_dlat_core_ls (
    .clk(clk), .rst(rst), .set_in(s_pin[3]), .clr_in(r_pin[3]),
    .q(q_o[3]), .q_n(qn_o[3]), .both_flag(f_o[3]));

  bit mq[4], mqn[4], mf[4];
  bit prev_both = 0;

  task automatic cycle(input bit s, input bit r, input bit rs);
    string tg;
    rst = rs;
    for (int v = 0; v < 4; v++) begin
      s_pin[v] = (v < 2) ? s : ~s;
      r_pin[v] = (v < 2) ? r : ~r;
    end
    for (int v = 0; v < 4; v++) begin
      bit d = (v % 2 == 1);
      mf[v] = 0;
      if (rs) begin mq[v] = 0; mqn[v] = 1; end
      else if (s && r) begin mq[v] = d; mqn[v] = d; mf[v] = 1; end
      else if (s) begin mq[v] = 1; mqn[v] = 0; end
      else if (r) begin mq[v] = 0; mqn[v] = 1; end
      else mqn[v] = ~mq[v];
    end
    @(posedge clk);
    @(negedge clk);
    for (int v = 0; v < 4; v++) begin
      if (rs) tg = "R1";
      else if (s && r) tg = (v % 2 == 1) ? "R6" : "R5";
      else if (s) tg = "R3+R7";
      else if (r) tg = "R4+R7";
      else tg = prev_both ? "R10+R7" : "R2+R7";
      tg = {tg, "+R8"};
      if (v >= 2) tg = {"R9/", tg};
      nvec++;
      if (q_o[v] !== mq[v] || qn_o[v] !== mqn[v] || f_o[v] !== mf[v]) begin
        nerr++;
        $display("FAIL %s variant %0d: q=%b q_n=%b flag=%b expected %b %b %b",
                 tg, v, q_o[v], qn_o[v], f_o[v], mq[v], mqn[v], mf[v]);
      end
    end
    prev_both = s && r && !rs;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < 4; v++) begin mq[v] = 0; mqn[v] = 1; end
    cycle(0, 0, 1);  // R1
    cycle(1, 1, 1);  // R1 with both active during reset
    cycle(0, 0, 0);  // R2 hold zero
    cycle(1, 0, 0);  // R3
    cycle(0, 0, 0);  // R2 hold one
    cycle(0, 1, 0);  // R4
    cycle(1, 1, 0);  // R5 / R6 / R8
    cycle(1, 1, 0);
    cycle(0, 0, 0);  // R10 release together
    cycle(0, 0, 0);
    cycle(1, 0, 0);
    cycle(1, 1, 0);
    cycle(1, 0, 0);  // leave both via set only
    cycle(1, 1, 0);
    cycle(0, 1, 0);  // leave both via clear only
    cycle(1, 1, 0);
    cycle(1, 1, 1);  // R1 reset wins over both active
    cycle(0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      bit rs = ($urandom % 29) == 0;
      cycle(1'($urandom), 1'($urandom), rs);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule